// File: doc/BRIEF.md
# Tile Fetch Address Generator

This block steps through the visible cells of a 32 x 24 tile map in raster order. It produces the memory reads needed to draw each cell. For every cell it first puts out the address of the cell's map entry. It then waits for the index byte to come back. From that byte it works out where the cell's 32-byte pattern lives, and puts out the 32 pattern byte addresses one per cycle. Then it moves on to the next cell. The two leftmost map columns are never fetched, so each frame covers 30 x 24 cells. After the last cell the walk wraps back to the first visible cell.

Two write-only configuration registers sit on an I/O write port. Port 0xFE sets the base of a 32-slot pattern area in RAM. Port 0xFF sets the base of the pattern bank in cartridge space, and also carries a flag that sends every index to the cartridge bank. Indices 0xE0 to 0xFF use the RAM area unless that flag is set. All other indices always use the cartridge bank.

The controller has three states, all named in `fetch_state_t`:
- `S_MAP` puts out the map entry address for one cycle. It always moves on to `S_WAIT`.
- `S_WAIT` keeps `addr_valid` low and stays in `S_WAIT` until `rd_valid` is seen. When `rd_valid` arrives it captures the pattern base and moves to `S_PAT`.
- `S_PAT` counts through the 32 pattern bytes. After the 32nd byte it advances the grid cursor and returns to `S_MAP`.

Top module: `tile_addr_gen`

## Requirements
- R1: Reset clears the RAM nibble, the cartridge bank and the flag to zero. While reset is held, and on the first cycle after it, the output is a valid map address 0xB802 (column 2, row 0).
- R2: A map address is 0xB800 + row*32 + column and is valid for exactly one cycle. Columns run from 2 to 31 inside a row, and rows run from 0 to 23. After column 31 of row 23 the walk returns to column 2 of row 0.
- R3: After a map address, `addr_valid` stays low until a cycle with `rd_valid` high. `rd_data` in that cycle is taken as the tile index.
- R4: After the index is captured, the block puts out 32 pattern addresses on 32 consecutive cycles: base, base+1, up to base+31, each with `addr_valid` high. The next map address follows directly after them.
- R5: The cartridge bank is set by bits 7:5 of a write to port 0xFF, and is worth bits 7:5 x 0x2000. The flag is bit 4 of that same write. If the index is below 0xE0, or the flag is 1, the pattern base is the cartridge bank + index*32.
- R6: The RAM nibble n is set by bits 7:4 of a write to port 0xFE, and gives a RAM base of (n*4+3)*0x400. If the index is 0xE0 or above and the flag is 0, the pattern base is the RAM base + (index mod 32)*32.
- R7: A write to any port other than 0xFE or 0xFF changes no configuration. Later pattern addresses show this.
- R8: A pulse on `rd_valid` outside the wait phase has no effect on the addresses that come out.
- R9: The pattern base is fixed when the index is captured. A configuration write made during the pattern burst only affects later cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| mem_addr | output | 16 | Memory read address |
| addr_valid | output | 1 | mem_addr holds a read request this cycle |
| rd_valid | input | 1 | Read data is returned this cycle |
| rd_data | input | 8 | Returned read data (tile index) |

## Verification
The assertions check several rules on every cycle:
- the cursor never leaves columns 2 to 31 or rows 0 to 23;
- a map cycle is always followed by a silent wait;
- the wait holds until data returns;
- each pattern address is one more than the one before;
- writes to other ports and stray `rd_valid` pulses leave state unchanged.

Only the bench's scenarios can show that the source is chosen correctly for each index. They cover the boundary indices 0xDF, 0xE0 and 0xFF, with the flag both set and clear, and configuration writes that land in the middle of a burst. The scenarios also show that the raster wraps correctly after a complete frame.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
    typedef enum logic [1:0] {
        S_MAP  = 2'd0,
        S_WAIT = 2'd1,
        S_PAT  = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/tfa_cfg_regs.sv
module tfa_cfg_regs #(
    parameter logic [7:0] RAM_PORT  = 8'hFE,
    parameter logic [7:0] CART_PORT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] io_port,
    input  logic [7:0] io_data,
    output logic [3:0] ram_nib,
    output logic [2:0] cart_bank,
    output logic       force_cart
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_nib    <= '0;
            cart_bank  <= '0;
            force_cart <= 1'b0;
        end else if (io_wr) begin
            if (io_port == RAM_PORT) ram_nib <= io_data[7:4];
            if (io_port == CART_PORT) begin
                cart_bank  <= io_data[7:5];
                force_cart <= io_data[4];
            end
        end
    end

    // R7: writes to unrelated ports leave configuration untouched
    p_other_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port != RAM_PORT && io_port != CART_PORT)
        |=> ($stable(ram_nib) && $stable(cart_bank) && $stable(force_cart)));
endmodule

// File: rtl/tfa_grid_cursor.sv
module tfa_grid_cursor #(
    parameter int COLS      = 32,
    parameter int ROWS      = 24,
    parameter int FIRST_COL = 2,
    localparam int CW = $clog2(COLS),
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= CW'(FIRST_COL);
            row <= '0;
        end else if (step) begin
            if (col == CW'(COLS - 1)) begin
                col <= CW'(FIRST_COL);
                row <= (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
            end else begin
                col <= col + CW'(1);
            end
        end
    end

    // R2: cursor stays inside the visible window
    p_cursor_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (col >= CW'(FIRST_COL)) && (row <= RW'(ROWS - 1)));
endmodule

// File: rtl/tfa_pat_base.sv
module tfa_pat_base #(
    parameter int         ADDR_W     = 16,
    parameter int         TILE_BYTES = 32,
    parameter logic [7:0] RAM_FIRST  = 8'hE0
) (
    input  logic [7:0]        idx,
    input  logic [3:0]        ram_nib,
    input  logic [2:0]        cart_bank,
    input  logic              force_cart,
    output logic [ADDR_W-1:0] base
);
    localparam int OFS = $clog2(TILE_BYTES);
    localparam int RSW = $clog2(256 - int'(RAM_FIRST));

    logic [ADDR_W-1:0] cart_base;
    logic [ADDR_W-1:0] ram_base;
    logic              use_ram;

    always_comb begin
        cart_base = ADDR_W'({cart_bank, 13'd0});
        ram_base  = ADDR_W'({ram_nib, 2'b11, 10'd0});
        use_ram   = !force_cart && (idx >= RAM_FIRST);
        if (use_ram)
            base = ram_base + (ADDR_W'(idx[RSW-1:0]) << OFS);
        else
            base = cart_base + (ADDR_W'(idx) << OFS);
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
    parameter int ADDR_W     = 16,
    parameter int MAP_BASE   = 16'hB800,
    parameter int MAP_COLS   = 32,
    parameter int MAP_ROWS   = 24,
    parameter int FIRST_COL  = 2,
    parameter int TILE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_port,
    input  logic [7:0]        io_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              addr_valid,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data
);
    import tfa_pkg::*;

    localparam int CW = $clog2(MAP_COLS);
    localparam int RW = $clog2(MAP_ROWS);
    localparam int BW = $clog2(TILE_BYTES);

    fetch_state_t      state, nxt;
    logic [CW-1:0]     col;
    logic [RW-1:0]     row;
    logic [BW-1:0]     byte_cnt;
    logic [ADDR_W-1:0] pat_base_q, base_next, map_addr;
    logic [3:0]        ram_nib;
    logic [2:0]        cart_bank;
    logic              force_cart, last_byte, step;

    tfa_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_data(io_data), .ram_nib(ram_nib), .cart_bank(cart_bank),
        .force_cart(force_cart)
    );

    tfa_grid_cursor #(.COLS(MAP_COLS), .ROWS(MAP_ROWS), .FIRST_COL(FIRST_COL)) u_cur (
        .clk(clk), .rst_n(rst_n), .step(step), .col(col), .row(row)
    );

    tfa_pat_base #(.ADDR_W(ADDR_W), .TILE_BYTES(TILE_BYTES)) u_base (
        .idx(rd_data), .ram_nib(ram_nib), .cart_bank(cart_bank),
        .force_cart(force_cart), .base(base_next)
    );

    assign last_byte = (byte_cnt == BW'(TILE_BYTES - 1));
    assign step      = (state == S_PAT) && last_byte;
    assign map_addr  = ADDR_W'(MAP_BASE) + ADDR_W'(row) * ADDR_W'(MAP_COLS) + ADDR_W'(col);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_MAP;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_MAP:   nxt = S_WAIT;
            S_WAIT:  nxt = rd_valid ? S_PAT : S_WAIT;
            S_PAT:   nxt = last_byte ? S_MAP : S_PAT;
            default: nxt = S_MAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt   <= '0;
            pat_base_q <= '0;
        end else if (state == S_WAIT && rd_valid) begin
            byte_cnt   <= '0;
            pat_base_q <= base_next;
        end else if (state == S_PAT) begin
            byte_cnt   <= byte_cnt + BW'(1);
        end
    end

    always_comb begin
        addr_valid = 1'b0;
        mem_addr   = '0;
        unique case (state)
            S_MAP: begin
                addr_valid = 1'b1;
                mem_addr   = map_addr;
            end
            S_WAIT: begin
                addr_valid = 1'b0;
            end
            S_PAT: begin
                addr_valid = 1'b1;
                mem_addr   = pat_base_q + ADDR_W'(byte_cnt);
            end
            default: begin
                addr_valid = 1'b0;
            end
        endcase
    end

    // R3: a map cycle is always followed by a silent wait
    p_map_to_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MAP) |=> (state == S_WAIT && !addr_valid));

    // R3: wait holds until data returns
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !rd_valid) |=> (state == S_WAIT));

    // R4: pattern addresses advance by one
    p_pat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAT && !last_byte) |=> (addr_valid && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R8: stray data strobe during a burst leaves the captured base alone
    p_stray_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAT && rd_valid && !last_byte) |=> (state == S_PAT && $stable(pat_base_q)));
endmodule

// File: tb/sim_tile_addr_gen.sv
module sim_tile_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CELLS_PER_FRAME = 720;
    localparam int TARGET_CELLS = 2 * CELLS_PER_FRAME + 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic [7:0]  io_data = 8'h00;
    logic [15:0] mem_addr;
    logic        addr_valid;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'h00;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    int m_phase = 0, m_cnt = 0, m_col = 2, m_row = 0, m_base = 0;
    int m_nib = 0, m_bank = 0, m_force = 0, m_k = 0, m_ram = 0;
    int cyc = 0, pend = 0, dly = 0;

    tile_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_data(io_data), .mem_addr(mem_addr), .addr_valid(addr_valid),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int idx_of(int k);
        case (k % 8)
            1: return 8'hDF;
            3: return 8'hE0;
            5: return 8'hFF;
            default: return (k * 37 + (k / CELLS_PER_FRAME) * 91 + 7) % 256;
        endcase
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_col = 2; m_row = 0; m_base = 0;
            m_nib = 0; m_bank = 0; m_force = 0; m_k = 0;
        end else begin
            cyc++;
            case (m_phase)
                0: m_phase = 1;
                1: if (rd_valid) begin
                       if (rd_data < 8'hE0 || m_force != 0) begin
                           m_base = m_bank * 8192 + rd_data * 32; m_ram = 0;
                       end else begin
                           m_base = (m_nib * 4 + 3) * 1024 + (rd_data % 32) * 32; m_ram = 1;
                       end
                       m_cnt = 0; m_phase = 2;
                   end
                default: if (m_cnt == 31) begin
                       m_phase = 0; m_k++;
                       if (m_col == 31) begin
                           m_col = 2; m_row = (m_row == 23) ? 0 : m_row + 1;
                       end else m_col++;
                   end else m_cnt++;
            endcase
            // configuration applies after the edge that samples it (R9)
            if (io_wr && io_port == 8'hFE) m_nib = io_data / 16;
            if (io_wr && io_port == 8'hFF) begin
                m_bank = io_data / 32; m_force = (io_data / 16) % 2;
            end
        end
    end

    // compare and drive stimulus away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (!(addr_valid && mem_addr == 16'hB802)) begin
                errors++;
                $display("FAIL R1 reset: valid=%0b addr=%h expected valid=1 addr=b802", addr_valid, mem_addr);
            end
        end else begin
            int ev, ea;
            ev = (m_phase != 1);
            ea = (m_phase == 0) ? 16'hB800 + m_row * 32 + m_col :
                 (m_phase == 2) ? m_base + m_cnt : 0;
            checks++;
            if (addr_valid !== ev[0] || (ev != 0 && mem_addr !== ea[15:0])) begin
                errors++;
                if (m_phase == 0)
                    $display("FAIL R1/R2 map cell %0d: valid=%0b addr=%h expected valid=%0b addr=%h", m_k, addr_valid, mem_addr, ev[0], ea[15:0]);
                else if (m_phase == 1)
                    $display("FAIL R3 wait: valid=%0b expected 0", addr_valid);
                else if (m_ram != 0)
                    $display("FAIL R4/R6/R7/R8/R9 pattern: addr=%h expected %h", mem_addr, ea[15:0]);
                else
                    $display("FAIL R4/R5/R7/R8/R9 pattern: addr=%h expected %h", mem_addr, ea[15:0]);
            end
            // responder: index returned after a per-cell delay (R3)
            rd_valid = 1'b0; rd_data = 8'h00;
            if (m_phase == 0) begin
                pend = 1; dly = m_k % 3;
            end else if (pend != 0) begin
                if (dly == 0) begin
                    rd_valid = 1'b1; rd_data = 8'(idx_of(m_k)); pend = 0;
                end else dly--;
            end else if (m_phase == 2 && m_cnt == 5) begin
                rd_valid = 1'b1; rd_data = 8'hEA; // R8 stray strobe
            end
            // configuration traffic, some of it mid-burst (R9) and to other ports (R7)
            io_wr = 1'b0; io_port = 8'h00; io_data = 8'h00;
            if (cyc % 997 == 10) begin
                io_wr = 1'b1; io_port = 8'hFE; io_data = 8'((cyc * 29) % 256);
            end else if (cyc % 1499 == 20) begin
                io_wr = 1'b1; io_port = 8'hFF; io_data = 8'((cyc * 13) % 256);
            end else if (cyc % 701 == 30) begin
                io_wr = 1'b1; io_port = 8'hFD; io_data = 8'hFF;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (m_k == TARGET_CELLS);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: cells=%0d expected %0d", m_k, TARGET_CELLS);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule